// File: doc/BRIEF.md
# Input Clock Switchover Controller

This block chooses which of two reference clocks, a primary and a secondary, drives a downstream clock consumer such as a PLL reference input. It runs from a free-running monitor clock. It watches both references for loss of toggling and raises a separate stopped-clock flag for each one. It also takes a lock-status input back from the consumer. A gated output clock carries the chosen reference. An active-clock indicator reports which reference is really reaching the output, and a select output reports which reference the controller has chosen.

The switching policy is fixed when the block is built, and there are three of them:
- **Manual**: the level of the switch input alone picks the reference.
- **Automatic**: the controller fails over when lock is lost or when the current reference stops.
- **Automatic with override**: the controller fails over when lock is lost, and each new assertion of the switch input toggles the selection.

A build-time wait can hold off the change until a set number of cycles of the target clock have passed. The handoff itself is glitch-free. The old reference is gated off on its own falling edge before the new one is gated on at its falling edge. A reference that has stopped is forced off, so a dead clock cannot stall the handoff. A build without the secondary input always passes the primary through.

Top module: `clksw_top`

## Requirements
- R1: After reset, sel_out is 0, active_out is 0, and both bad flags are 0.
- R2: A bad flag rises within STOP_LIMIT+4 monitor cycles after its input stops toggling. It stays 0 while that input toggles, and it returns to 0 within a few monitor cycles once edges resume.
- R3: active_out is 0 while the primary drives clk_out and 1 while the secondary drives it. active_out only ever moves to the value of sel_out. The two clock gates are never open at the same time, and once active_out is 1, clk_out equals clk_sec.
- R4: In manual mode (MODE=0), sel_out follows the synchronized level of switch_in (0 selects primary, 1 selects secondary). lock_in has no effect in this mode.
- R5: In automatic mode (MODE=1), a falling edge on lock_in toggles the selection. The selection also moves away from the primary when bad_pri rises while the primary is selected.
- R6: In both automatic modes, the selection never moves to an input whose bad flag is set. If both inputs are bad, the current selection is held.
- R7: In override mode (MODE=2), each rising edge of switch_in toggles the selection exactly once, however long the input is held high, and a falling edge on lock_in also toggles it.
- R8: With WAIT_CYCLES=N>0, sel_out changes only after N rising edges of the target clock have been seen after the request.
- R9: A request that arrives before active_out has reached the current selection is dropped, and sel_out changes only while active_out equals sel_out.
- R10: With SW_EN=0, sel_out and active_out stay 0 and clk_out equals clk_pri, whatever switch_in and lock_in do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_mon | input | 1 | Free-running monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pri | input | 1 | Primary reference clock |
| clk_sec | input | 1 | Secondary reference clock |
| switch_in | input | 1 | Switch request: a level in manual mode, a rising edge in override mode |
| lock_in | input | 1 | Consumer lock status; a falling edge means lock was lost |
| clk_out | output | 1 | Glitch-free gated reference to the consumer |
| sel_out | output | 1 | Chosen reference: 0 = primary, 1 = secondary |
| active_out | output | 1 | Reference actually driving clk_out: 0 = primary, 1 = secondary |
| bad_pri | output | 1 | Primary stopped toggling |
| bad_sec | output | 1 | Secondary stopped toggling |

## Verification
The bench builds four copies of the block, each aimed at different requirements:
- An override copy with WAIT_CYCLES=4 makes the hold-off window and the dropped mid-wait request observable (R8, R9).
- A manual copy and an automatic copy with no wait cover the level-driven and failover policies. The automatic copy also covers the refusal to move onto a stopped input while one or both references are halted (R4, R5, R6).
- A copy with SW_EN=0 shows the pass-through build (R10).

All copies use STOP_LIMIT=8, so stopping either reference brings up its bad flag quickly and exercises the forced-off path of the gate.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    SW_MANUAL   = 2'd0,
    SW_AUTO     = 2'd1,
    SW_AUTO_OVR = 2'd2
  } sw_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HAND = 2'd2
  } sw_state_e;
endpackage

// File: rtl/clksw_actmon.sv
module clksw_actmon #(
  parameter int unsigned STOP_LIMIT = 8
) (
  input  logic clk_mon,
  input  logic rst_n,
  input  logic clk_in,
  output logic rise_o,
  output logic bad_o
);
  localparam int unsigned CW = $clog2(STOP_LIMIT + 1);

  logic [2:0]    smp_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          toggle;
  logic          cnt_en;

  // raw input clock sampled into the monitor domain
  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[1:0], clk_in};
  end

  assign toggle = smp_q[2] ^ smp_q[1];
  assign rise_o = smp_q[1] & ~smp_q[2];
  assign cnt_en = toggle | (cnt_q != CW'(STOP_LIMIT));

  always_comb begin
    cnt_d = cnt_q;
    if (toggle) cnt_d = '0;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign bad_o = (cnt_q == CW'(STOP_LIMIT));
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter sw_mode_e    MODE        = SW_AUTO_OVR,
  parameter int unsigned WAIT_CYCLES = 0
) (
  input  logic clk_mon,
  input  logic rst_n,
  input  logic sw_in,
  input  logic lock_in,
  input  logic bad0,
  input  logic bad1,
  input  logic rise0,
  input  logic rise1,
  input  logic active,
  output logic sel_o
);
  localparam int unsigned WCW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1;

  logic [2:0]     sw_q, lock_q;
  sw_state_e      state_q, state_d;
  logic           sel_q, sel_d;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           sw_s, sw_rise, lock_fall;
  logic           bad_cur, bad_tgt, rise_tgt, trig;

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      lock_q <= '0;
    end else begin
      sw_q   <= {sw_q[1:0], sw_in};
      lock_q <= {lock_q[1:0], lock_in};
    end
  end

  assign sw_s      = sw_q[1];
  assign sw_rise   = sw_q[1] & ~sw_q[2];
  assign lock_fall = ~lock_q[1] & lock_q[2];
  assign bad_cur   = sel_q ? bad1 : bad0;
  assign bad_tgt   = sel_q ? bad0 : bad1;
  assign rise_tgt  = sel_q ? rise0 : rise1;

  always_comb begin
    if (MODE == SW_MANUAL)   trig = (sw_s != sel_q);
    else if (MODE == SW_AUTO) trig = (lock_fall | bad_cur) & ~bad_tgt;
    else                      trig = (lock_fall | sw_rise) & ~bad_tgt;
  end

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    wcnt_d  = wcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig) begin
          if (WAIT_CYCLES == 0) begin
            sel_d   = ~sel_q;
            state_d = ST_HAND;
          end else begin
            wcnt_d  = '0;
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if ((MODE != SW_MANUAL) && bad_tgt) begin
          state_d = ST_IDLE;
        end else if (rise_tgt) begin
          if (wcnt_q == WCW'(WAIT_CYCLES - 1)) begin
            sel_d   = ~sel_q;
            state_d = ST_HAND;
          end else begin
            wcnt_d = wcnt_q + 1'b1;
          end
        end
      end
      ST_HAND: begin
        if (active == sel_q) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/clksw_gfmux.sv
module clksw_gfmux (
  input  logic clk_mon,
  input  logic rst_n,
  input  logic clk0,
  input  logic clk1,
  input  logic sel,
  input  logic bad0,
  input  logic bad1,
  output logic clk_o,
  output logic en0_o,
  output logic en1_o,
  output logic active_o
);
  logic       kill0_q, kill1_q;
  logic       rst0_n, rst1_n;
  logic [1:0] e0_q, e1_q;
  logic [1:0] a0_q, a1_q;
  logic       act_q;

  // a stopped, deselected clock is forced off from the monitor domain
  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      kill0_q <= 1'b0;
      kill1_q <= 1'b0;
    end else begin
      kill0_q <= bad0 & sel;
      kill1_q <= bad1 & ~sel;
    end
  end

  assign rst0_n = rst_n & ~kill0_q;
  assign rst1_n = rst_n & ~kill1_q;

  always_ff @(negedge clk0 or negedge rst0_n) begin
    if (!rst0_n) e0_q <= 2'b00;
    else         e0_q <= {e0_q[0], ~sel & ~e1_q[1]};
  end

  always_ff @(negedge clk1 or negedge rst1_n) begin
    if (!rst1_n) e1_q <= 2'b00;
    else         e1_q <= {e1_q[0], sel & ~e0_q[1]};
  end

  assign en0_o = e0_q[1];
  assign en1_o = e1_q[1];
  assign clk_o = (clk0 & e0_q[1]) | (clk1 & e1_q[1]);

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) begin
      a0_q  <= 2'b00;
      a1_q  <= 2'b00;
      act_q <= 1'b0;
    end else begin
      a0_q <= {a0_q[0], e0_q[1]};
      a1_q <= {a1_q[0], e1_q[1]};
      if (a1_q[1])      act_q <= 1'b1;
      else if (a0_q[1]) act_q <= 1'b0;
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter sw_mode_e    MODE        = SW_AUTO_OVR,
  parameter bit          SW_EN       = 1'b1,
  parameter int unsigned STOP_LIMIT  = 8,
  parameter int unsigned WAIT_CYCLES = 0
) (
  input  logic clk_mon,
  input  logic rst_n,
  input  logic clk_pri,
  input  logic clk_sec,
  input  logic switch_in,
  input  logic lock_in,
  output logic clk_out,
  output logic sel_out,
  output logic active_out,
  output logic bad_pri,
  output logic bad_sec
);
  logic [1:0] rs_q;
  logic       rst_mon_n;
  logic       rise_pri;
  logic       en_pri, en_sec;

  always_ff @(posedge clk_mon or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_mon_n = rs_q[1];

  clksw_actmon #(.STOP_LIMIT(STOP_LIMIT)) u_mon_pri (
    .clk_mon(clk_mon), .rst_n(rst_mon_n), .clk_in(clk_pri),
    .rise_o(rise_pri), .bad_o(bad_pri)
  );

  if (SW_EN) begin : g_dual
    logic rise_sec;

    clksw_actmon #(.STOP_LIMIT(STOP_LIMIT)) u_mon_sec (
      .clk_mon(clk_mon), .rst_n(rst_mon_n), .clk_in(clk_sec),
      .rise_o(rise_sec), .bad_o(bad_sec)
    );

    clksw_ctrl #(.MODE(MODE), .WAIT_CYCLES(WAIT_CYCLES)) u_ctrl (
      .clk_mon(clk_mon), .rst_n(rst_mon_n), .sw_in(switch_in),
      .lock_in(lock_in), .bad0(bad_pri), .bad1(bad_sec),
      .rise0(rise_pri), .rise1(rise_sec), .active(active_out),
      .sel_o(sel_out)
    );

    clksw_gfmux u_mux (
      .clk_mon(clk_mon), .rst_n(rst_mon_n), .clk0(clk_pri), .clk1(clk_sec),
      .sel(sel_out), .bad0(bad_pri), .bad1(bad_sec), .clk_o(clk_out),
      .en0_o(en_pri), .en1_o(en_sec), .active_o(active_out)
    );
  end else begin : g_single
    assign bad_sec    = 1'b0;
    assign sel_out    = 1'b0;
    assign active_out = 1'b0;
    assign clk_out    = clk_pri;
    assign en_pri     = 1'b1;
    assign en_sec     = 1'b0;
  end
endmodule

// File: rtl/clksw_chk.sv
module clksw_chk
  import clksw_pkg::*;
#(
  parameter sw_mode_e MODE = SW_AUTO_OVR
) (
  input logic clk_mon,
  input logic rst_n,
  input logic sel,
  input logic active,
  input logic bad_pri,
  input logic bad_sec,
  input logic rise_pri,
  input logic en_pri,
  input logic en_sec
);
  p_gates_exclusive_r3: assert property (@(posedge clk_mon) disable iff (!rst_n)
    !(en_pri && en_sec));

  p_active_moves_to_sel_r3: assert property (@(posedge clk_mon) disable iff (!rst_n)
    !$stable(active) |-> (active == sel));

  p_sel_after_handoff_r9: assert property (@(posedge clk_mon) disable iff (!rst_n)
    !$stable(sel) |-> ($past(active) == $past(sel)));

  p_no_bad_target_r6: assert property (@(posedge clk_mon) disable iff (!rst_n)
    ((MODE != SW_MANUAL) && !$stable(sel)) |-> (sel ? !$past(bad_sec) : !$past(bad_pri)));

  p_bad_clears_on_edge_r2: assert property (@(posedge clk_mon) disable iff (!rst_n)
    rise_pri |=> !bad_pri);
endmodule

bind clksw_top clksw_chk #(.MODE(MODE)) u_chk (
  .clk_mon(clk_mon), .rst_n(rst_mon_n), .sel(sel_out), .active(active_out),
  .bad_pri(bad_pri), .bad_sec(bad_sec), .rise_pri(rise_pri),
  .en_pri(en_pri), .en_sec(en_sec)
);

// File: tb/clksw_top_test.sv
module clksw_top_test;
  import clksw_pkg::*;

  logic clk_mon, rst_n;
  logic g0, g1, run0, run1;
  logic clk_pri, clk_sec;
  logic sw_o, lk_o, sw_m, lk_m, sw_a, lk_a, sw_s, lk_s;
  logic co_o, sel_o, act_o, bp_o, bs_o;
  logic co_m, sel_m, act_m, bp_m, bs_m;
  logic co_a, sel_a, act_a, bp_a, bs_a;
  logic co_s, sel_s, act_s, bp_s, bs_s;
  int   checks, errors;
  bit   done;

  initial begin clk_mon = 1'b0; forever #5 clk_mon = ~clk_mon; end
  initial begin g0 = 1'b0; forever #20 g0 = ~g0; end
  initial begin g1 = 1'b0; forever #30 g1 = ~g1; end
  assign clk_pri = g0 & run0;
  assign clk_sec = g1 & run1;

  clksw_top #(.MODE(SW_AUTO_OVR), .WAIT_CYCLES(4)) uut (
    .clk_mon(clk_mon), .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec),
    .switch_in(sw_o), .lock_in(lk_o), .clk_out(co_o), .sel_out(sel_o),
    .active_out(act_o), .bad_pri(bp_o), .bad_sec(bs_o));

  clksw_top #(.MODE(SW_MANUAL)) uut_man (
    .clk_mon(clk_mon), .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec),
    .switch_in(sw_m), .lock_in(lk_m), .clk_out(co_m), .sel_out(sel_m),
    .active_out(act_m), .bad_pri(bp_m), .bad_sec(bs_m));

  clksw_top #(.MODE(SW_AUTO)) uut_auto (
    .clk_mon(clk_mon), .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec),
    .switch_in(sw_a), .lock_in(lk_a), .clk_out(co_a), .sel_out(sel_a),
    .active_out(act_a), .bad_pri(bp_a), .bad_sec(bs_a));

  clksw_top #(.MODE(SW_AUTO), .SW_EN(1'b0)) uut_single (
    .clk_mon(clk_mon), .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec),
    .switch_in(sw_s), .lock_in(lk_s), .clk_out(co_s), .sel_out(sel_s),
    .active_out(act_s), .bad_pri(bp_s), .bad_sec(bs_s));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_mon);
    #1;
  endtask

  task automatic t_reset;
    chk("R1 sel after reset", sel_o, 1'b0);
    chk("R1 active after reset", act_o, 1'b0);
    chk("R1 bad_pri after reset", bp_o, 1'b0);
    chk("R1 bad_sec after reset", bs_o, 1'b0);
    cyc(60);
    chk("R2 bad_pri low while toggling", bp_a, 1'b0);
    chk("R2 bad_sec low while toggling", bs_a, 1'b0);
  endtask

  task automatic t_manual;
    sw_m = 1'b1;
    cyc(80);
    chk("R4 manual sel follows switch high", sel_m, 1'b1);
    chk("R3 manual active high on secondary", act_m, 1'b1);
    for (int i = 0; i < 6; i++) begin
      chk("R3 clk_out follows secondary", co_m, clk_sec);
      cyc(1);
    end
    lk_m = 1'b0;
    cyc(60);
    chk("R4 manual ignores lock loss", sel_m, 1'b1);
    sw_m = 1'b0;
    cyc(80);
    chk("R4 manual sel follows switch low", sel_m, 1'b0);
    chk("R3 manual active low on primary", act_m, 1'b0);
    lk_m = 1'b1;
    cyc(5);
  endtask

  task automatic t_single;
    sw_s = 1'b1; lk_s = 1'b0;
    cyc(60);
    sw_s = 1'b0; lk_s = 1'b1;
    cyc(20);
    chk("R10 single sel stays primary", sel_s, 1'b0);
    chk("R10 single active stays primary", act_s, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R10 single clk_out is primary", co_s, clk_pri);
      cyc(1);
    end
  endtask

  task automatic t_override;
    sw_o = 1'b1; cyc(3); sw_o = 1'b0;
    cyc(7);
    chk("R8 sel held during wait window", sel_o, 1'b0);
    sw_o = 1'b1; cyc(3); sw_o = 1'b0;
    cyc(100);
    chk("R7 override rising edge toggles", sel_o, 1'b1);
    chk("R3 override active follows", act_o, 1'b1);
    cyc(100);
    chk("R9 request during wait dropped", sel_o, 1'b1);
    sw_o = 1'b1;
    cyc(150);
    chk("R7 held switch toggles once", sel_o, 1'b0);
    chk("R7 held switch active back to primary", act_o, 1'b0);
    sw_o = 1'b0;
    cyc(20);
    lk_o = 1'b0;
    cyc(100);
    chk("R7 override lock loss toggles", sel_o, 1'b1);
    lk_o = 1'b1;
    cyc(10);
  endtask

  task automatic t_auto;
    lk_a = 1'b0;
    cyc(80);
    chk("R5 auto lock loss to secondary", sel_a, 1'b1);
    chk("R5 auto active secondary", act_a, 1'b1);
    lk_a = 1'b1; cyc(5);
    lk_a = 1'b0;
    cyc(80);
    chk("R5 auto second lock loss to primary", sel_a, 1'b0);
    lk_a = 1'b1; cyc(5);
    run0 = 1'b0;
    cyc(30);
    chk("R2 bad_pri rises after stop", bp_a, 1'b1);
    cyc(80);
    chk("R5 auto failover on primary stop", sel_a, 1'b1);
    chk("R5 auto active after failover", act_a, 1'b1);
    for (int i = 0; i < 6; i++) begin
      chk("R3 auto clk_out follows secondary", co_a, clk_sec);
      cyc(1);
    end
    run0 = 1'b1;
    cyc(20);
    chk("R2 bad_pri clears after restart", bp_a, 1'b0);
    run0 = 1'b0;
    cyc(30);
    lk_a = 1'b0;
    cyc(80);
    chk("R6 no switch onto bad primary", sel_a, 1'b1);
    run1 = 1'b0;
    cyc(80);
    chk("R2 bad_sec rises after stop", bs_a, 1'b1);
    chk("R6 both bad hold selection", sel_a, 1'b1);
    run0 = 1'b1; run1 = 1'b1; lk_a = 1'b1;
    cyc(30);
    chk("R2 bad_sec clears after restart", bs_a, 1'b0);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; run0 = 1'b1; run1 = 1'b1;
    sw_o = 1'b0; lk_o = 1'b1; sw_m = 1'b0; lk_m = 1'b1;
    sw_a = 1'b0; lk_a = 1'b1; sw_s = 1'b0; lk_s = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_single();
    t_manual();
    t_override();
    t_auto();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_mon);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule